// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-bit storage register that can hold its value, shift in either direction, or take a parallel word, all on the rising clock edge. The parallel input word and the register's parallel output share one set of bus lines. In this code base that shared set is modelled as an input word, an output word and a drive-enable. The drive-enable stands for the tri-state control of the lines. The bus is driven only when both output enables are asserted and the block is not loading. During a load the drivers are forced off, so that the bus can be sampled.

Each shift direction has its own serial input. Two dedicated outputs always show the lowest and highest register bits. Two or more registers can therefore be chained through their serial pins to form a longer shifter. An asynchronous active-low reset clears the contents at any time.

Top module: `univ_shift_reg`

## Requirements
- R1: While `rst_n` is low, the register is zero, and it becomes zero without waiting for a clock edge. Clock edges that arrive while `rst_n` is low leave it at zero, whatever the mode select.
- R2: With `sel` = 2'b00 (hold), a rising edge leaves the register unchanged.
- R3: With `sel` = 2'b01 (shift right), a rising edge moves every bit one place toward the top bit. Bit 0 takes `ser_r_in` and the old top bit is dropped.
- R4: With `sel` = 2'b10 (shift left), a rising edge moves every bit one place toward bit 0. The top bit takes `ser_l_in` and the old bit 0 is dropped.
- R5: With `sel` = 2'b11 (load), a rising edge copies `bus_in` into the register.
- R6: `bus_drive` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `sel` is not 2'b11. Either enable at 1, or load mode, releases the bus.
- R7: While `bus_drive` is 1, `bus_out` equals the register contents. While `bus_drive` is 0, `bus_out` is all zeros.
- R8: `end_lo` always equals register bit 0 and `end_hi` always equals register bit 7, whatever the output enables and the mode.
- R9: Two registers can be chained, with the top bit of the first feeding the right-shift input of the second, and bit 0 of the second feeding the left-shift input of the first. The chain then acts as one 16-bit shifter in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every mode acts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Mode: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r_in | input | 1 | New bit 0 during a right shift |
| ser_l_in | input | 1 | New top bit during a left shift |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| bus_in | input | 8 | Value sampled from the shared bus lines |
| bus_out | output | 8 | Value driven onto the shared bus lines |
| bus_drive | output | 1 | 1 while the block drives the bus lines |
| end_lo | output | 1 | Register bit 0, for chaining |
| end_hi | output | 1 | Register bit 7, for chaining |

## Verification
Several properties are checked on every cycle. Each of the four modes must produce its next register value from the previous one, and reset must always leave a cleared register. Whenever loading is selected the bus must be released, and the driven bus word must follow the register. The bench's scenarios cover the rest. They sweep every mode against every enable combination over a set of data patterns. They show that reset clears the register between clock edges. They show that two chained registers carry bits across the join in both directions, over sixteen shifts.

// File: rtl/usr_pkg.sv
// Package: shared mode type for the universal shift register.
// Assumes the two-bit select is decoded directly into this encoding.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_mode_dec.sv
// Module: usr_mode_dec
// Turns the raw two-bit select into the mode type and flags load mode.
// Assumes the select is stable around the rising clock edge.
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    output usr_mode_e  mode,
    output logic       is_load
);

    // Purpose: map the select onto the mode enumeration and the load flag.
    always_comb begin
        mode    = usr_mode_e'(sel);
        is_load = (mode == MODE_LOAD);
    end

endmodule

// File: rtl/usr_core.sv
// Module: usr_core
// Holds the storage register and computes its next value for each mode.
// The per-bit muxes are generated, so the width is set by a parameter.
// Assumes clear is asynchronous and active low.
module usr_core
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  usr_mode_e    mode,
    input  logic         ser_r,
    input  logic         ser_l,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);

    localparam int TOP = W - 1;

    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_lo;
        logic from_hi;

        if (i == 0) begin : g_lo_edge
            // Purpose: bit 0 takes the right-shift serial input.
            always_comb from_lo = ser_r;
        end else begin : g_lo_mid
            // Purpose: a right shift takes the lower neighbour.
            always_comb from_lo = q[i-1];
        end

        if (i == TOP) begin : g_hi_edge
            // Purpose: the top bit takes the left-shift serial input.
            always_comb from_hi = ser_l;
        end else begin : g_hi_mid
            // Purpose: a left shift takes the upper neighbour.
            always_comb from_hi = q[i+1];
        end

        // Purpose: choose this bit's next value by mode.
        always_comb begin
            unique case (mode)
                MODE_SHR:  nxt[i] = from_lo;
                MODE_SHL:  nxt[i] = from_hi;
                MODE_LOAD: nxt[i] = par_in[i];
                default:   nxt[i] = q[i];
            endcase
        end
    end

    // Purpose: the register, with asynchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R1
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q)); // R2
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHR) |=> (q == {$past(q[TOP-1:0]), $past(ser_r)})); // R3
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHL) |=> (q == {$past(ser_l), $past(q[TOP:1])})); // R4
    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(par_in))); // R5

endmodule

// File: rtl/usr_bus_drv.sv
// Module: usr_bus_drv
// Models the tri-state parallel outputs as a drive-enable and a driven word.
// The word is zero while released, so that nothing leaks onto the bus.
// Assumes both enables are active low.
module usr_bus_drv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] q,
    input  logic         is_load,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    output logic [W-1:0] bus_out,
    output logic         bus_drive
);

    // Purpose: drive only with both enables low and no load in progress.
    always_comb begin
        bus_drive = !oe_a_n && !oe_b_n && !is_load;
        bus_out   = bus_drive ? q : '0;
    end

    AST_LOAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |-> !bus_drive); // R6
    AST_BUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (bus_out == q)); // R7
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> (bus_out == '0)); // R7

endmodule

// File: rtl/univ_shift_reg.sv
// Module: univ_shift_reg (top)
// Universal shift register whose parallel input and output share bus lines.
// The end bits are brought out at all times so that registers can be chained.
// Assumes the caller ties the bus value back to bus_in when nobody else drives it.
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_drive,
    output logic         end_lo,
    output logic         end_hi
);

    localparam int TOP = W - 1;

    usr_mode_e    mode;
    logic         is_load;
    logic [W-1:0] q;

    usr_mode_dec u_dec (
        .sel     (sel),
        .mode    (mode),
        .is_load (is_load)
    );

    usr_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .ser_r  (ser_r_in),
        .ser_l  (ser_l_in),
        .par_in (bus_in),
        .q      (q)
    );

    usr_bus_drv #(.W(W)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .q         (q),
        .is_load   (is_load),
        .oe_a_n    (oe_a_n),
        .oe_b_n    (oe_b_n),
        .bus_out   (bus_out),
        .bus_drive (bus_drive)
    );

    // Purpose: expose the two end bits for chaining.
    always_comb begin
        end_lo = q[0];
        end_hi = q[TOP];
    end

endmodule

// File: tb/univ_shift_reg_tb_top.sv
module univ_shift_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       ser_r = 1'b0, ser_l = 1'b0, b_ser_l = 1'b0;
    logic       oea = 1'b1, oeb = 1'b1;
    logic [7:0] a_bus = 8'h00, b_bus = 8'h00;
    logic       casc = 1'b0;

    logic [7:0] a_out, b_out;
    logic       a_drv, b_drv, a_lo, a_hi, b_lo, b_hi;
    logic       a_ser_l, b_ser_r;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q;

    always #10 clk = ~clk;

    assign a_ser_l = casc ? b_lo : ser_l;
    assign b_ser_r = casc ? a_hi : 1'b0;

    univ_shift_reg dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_r_in(ser_r), .ser_l_in(a_ser_l),
        .oe_a_n(oea), .oe_b_n(oeb), .bus_in(a_bus), .bus_out(a_out),
        .bus_drive(a_drv), .end_lo(a_lo), .end_hi(a_hi)
    );

    univ_shift_reg dut_b (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_r_in(b_ser_r), .ser_l_in(b_ser_l),
        .oe_a_n(oea), .oe_b_n(oeb), .bus_in(b_bus), .bus_out(b_out),
        .bus_drive(b_drv), .end_lo(b_lo), .end_hi(b_hi)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Observe the register of dut_i via hold mode with both enables low.
    task automatic observe(input string req);
        @(negedge clk);
        sel = 2'b00; oea = 1'b0; oeb = 1'b0;
        #1;
        chk(a_drv === 1'b1 && a_out === exp_q, req, {7'd0, a_drv, a_out}, {8'h01, exp_q});
        chk(a_lo === exp_q[0] && a_hi === exp_q[7], "R8", {14'd0, a_hi, a_lo},
            {14'd0, exp_q[7], exp_q[0]});
    endtask

    // One mode step on dut_i, checking the bus drive before the edge.
    task automatic step(input logic [1:0] s, input logic [1:0] oe, input logic [7:0] d,
                        input logic sr, input logic sl);
        logic       e_drv;
        logic [7:0] e_bus;
        @(negedge clk);
        sel = s; oea = oe[0]; oeb = oe[1]; a_bus = d; ser_r = sr; ser_l = sl;
        #1;
        e_drv = (oe == 2'b00) && (s != 2'b11);
        e_bus = e_drv ? exp_q : 8'h00;
        chk(a_drv === e_drv, "R6", {15'd0, a_drv}, {15'd0, e_drv});
        chk(a_out === e_bus, "R7", {8'd0, a_out}, {8'd0, e_bus});
        chk(a_lo === exp_q[0] && a_hi === exp_q[7], "R8", {14'd0, a_hi, a_lo},
            {14'd0, exp_q[7], exp_q[0]});
        @(posedge clk);
        case (s)
            2'b01:   exp_q = {exp_q[6:0], sr};
            2'b10:   exp_q = {sl, exp_q[7:1]};
            2'b11:   exp_q = d;
            default: exp_q = exp_q;
        endcase
        case (s)
            2'b00:   observe("R2");
            2'b01:   observe("R3");
            2'b10:   observe("R4");
            default: observe("R5");
        endcase
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] chain;
        exp_q = 8'h00;
        // R1: edges during reset, even in load mode, leave zero
        @(negedge clk);
        sel = 2'b11; a_bus = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        oea = 1'b0; oeb = 1'b0; sel = 2'b00;
        #1;
        chk(a_out === 8'h00 && a_drv === 1'b1, "R1", {7'd0, a_drv, a_out}, 16'h0100);
        #3 rst_n = 1'b1;

        // Sweep modes, enable pairs and data patterns.
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 4; e++) begin
                    step(2'(s), 2'(e), 8'(k * 37 + 5 + s * 11), 1'(k + e), 1'(k + s + e + 1));
                end
            end
        end

        // R1: asynchronous clear between edges, then edges while held low
        step(2'b11, 2'b00, 8'hC3, 1'b0, 1'b0);
        @(negedge clk);
        sel = 2'b00; oea = 1'b0; oeb = 1'b0;
        #3 rst_n = 1'b0;
        #1;
        chk(a_out === 8'h00, "R1", {8'd0, a_out}, 16'h0000);
        sel = 2'b11; a_bus = 8'h5A;
        @(posedge clk);
        @(posedge clk);
        #5;
        chk(a_lo === 1'b0 && a_hi === 1'b0, "R1", {14'd0, a_hi, a_lo}, 16'h0000);
        @(negedge clk);
        sel = 2'b00;
        #3 rst_n = 1'b1;
        exp_q = 8'h00;
        observe("R1");

        // R9: chain of two, right direction
        casc = 1'b1;
        @(negedge clk);
        sel = 2'b11; a_bus = 8'hA5; b_bus = 8'h3C;
        @(posedge clk);
        chain = 16'h3CA5;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sel = 2'b01; ser_r = 1'(i % 3 == 0);
            @(posedge clk);
            chain = {chain[14:0], ser_r};
            #5;
            chk(b_hi === chain[15] && a_hi === chain[7], "R9", {14'd0, b_hi, a_hi},
                {14'd0, chain[15], chain[7]});
        end
        @(negedge clk);
        sel = 2'b00; oea = 1'b0; oeb = 1'b0;
        #1;
        chk({b_out, a_out} === chain, "R9", {b_out, a_out}, chain);

        // R9: chain of two, left direction
        @(negedge clk);
        sel = 2'b11; a_bus = 8'h81; b_bus = 8'h6E;
        @(posedge clk);
        chain = 16'h6E81;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sel = 2'b10; b_ser_l = 1'(i % 4 == 1 || i % 5 == 0);
            @(posedge clk);
            chain = {b_ser_l, chain[15:1]};
            #5;
            chk(a_lo === chain[0] && b_lo === chain[8], "R9", {14'd0, b_lo, a_lo},
                {14'd0, chain[8], chain[0]});
        end
        @(negedge clk);
        sel = 2'b00; oea = 1'b0; oeb = 1'b0;
        #1;
        chk({b_out, a_out} === chain, "R9", {b_out, a_out}, chain);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule